// File: doc/BRIEF.md
# Thread-Shared Direct-Mapped Branch Target Buffer

This block predicts the destination of taken branches for a fetch unit that serves several hardware threads from one table. Each fetch cycle it receives a program counter and a thread number. Within the same cycle it reports whether the table holds a target for that pair, and what that target is. The table is direct-mapped. Each slot holds a valid flag, an address tag, the number of the thread that wrote it, and the target address.

When a branch resolves, the back end writes the branch address, the thread number and the real target through the update port. The write lands on the next clock edge and replaces the indexed slot, whatever the slot held before. The thread number is folded into the upper bits of the slot index. It is also compared on every lookup, so two threads running the same code do not pick up each other's predictions.

The table is emptied in two ways: by the asynchronous reset, or by a synchronous flush request. The slot count, tag width, instruction-offset shift and thread count are parameters.

Top module: `tbtb_top`

## Requirements
- R1: The slot index is `(pc >> OFS_SHIFT)` XOR `(tid << (log2(ENTRIES) - log2(THREADS)))`, reduced to log2(ENTRIES) bits. ENTRIES and THREADS are powers of two, with 2 <= THREADS <= ENTRIES.
- R2: The tag is `(pc >> (OFS_SHIFT + log2(ENTRIES)))`, reduced to TAG_W bits.
- R3: `lkHit` is 1 only when the indexed slot is valid, its stored tag equals the lookup tag, and its stored thread number equals `lkTid`.
- R4: When `lkHit` is 0, `lkTarget` is zero. A stored target of zero is returned with `lkHit` = 1.
- R5: With `updEn` = 1, the indexed slot is overwritten unconditionally on the next rising edge: valid is set, and the tag, thread number and target are stored. A lookup of the same pc and thread hits with that target from the following cycle onward.
- R6: A `flushReq` high at a rising edge invalidates every slot. If an update is presented at the same edge, the flush wins and the update is dropped.
- R7: While `rst_n` is low, and after it is released, every slot is invalid until it is updated.
- R8: A lookup and an update to the same slot in the same cycle return the slot's old contents. The new contents appear on the next cycle.
- R9: The same pc used by different threads maps to different slots. Table contents change only through updates, flushes and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all slots |
| flushReq | input | 1 | Synchronous request to invalidate all slots |
| lkPc | input | PC_W | Lookup program counter |
| lkTid | input | log2(THREADS) | Lookup thread number |
| lkHit | output | 1 | Lookup found a matching valid slot |
| lkTarget | output | TGT_W | Predicted target, zero on a miss |
| updEn | input | 1 | Write a resolved target this cycle |
| updPc | input | PC_W | Branch program counter for the write |
| updTid | input | log2(THREADS) | Thread number for the write |
| updTarget | input | TGT_W | Resolved target to store |

## Verification
Two pairs of functions can land in one cycle.

The first pair is a lookup and an update of the same slot. The bench drives both in one low clock phase and checks that the old contents are returned before the edge. At the next falling edge it checks that the new contents are returned.

The second pair is a flush and an update. The bench raises both together and then checks that the updated address misses. This shows that the flush took priority.

Thread aliasing, tag conflicts at one slot and lookups after reset are judged through full sweeps against an arithmetic model of the index and tag formulas.

// File: rtl/tbtb_pkg.sv
package tbtb_pkg;
  typedef struct packed {
    logic write;
    logic clearAll;
  } tbtbStrobeT;
endpackage

// File: rtl/tbtb_ctrl.sv
module tbtb_ctrl #(
  parameter int ENTRIES   = 16,
  parameter int TAG_W     = 8,
  parameter int OFS_SHIFT = 2,
  parameter int THREADS   = 4,
  parameter int PC_W      = 32,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TID_W    = $clog2(THREADS)
) (
  input  logic                       updEn,
  input  logic                       flushReq,
  input  logic [PC_W-1:0]            lkPc,
  input  logic [TID_W-1:0]           lkTid,
  input  logic [PC_W-1:0]            updPc,
  input  logic [TID_W-1:0]           updTid,
  output logic [IDX_W-1:0]           rdIdx,
  output logic [TAG_W-1:0]           rdTag,
  output logic [IDX_W-1:0]           wrIdx,
  output logic [TAG_W-1:0]           wrTag,
  output tbtb_pkg::tbtbStrobeT       strobe
);
  localparam int TID_SH = IDX_W - TID_W;
  localparam int TAG_LO = OFS_SHIFT + IDX_W;

  if ((ENTRIES & (ENTRIES - 1)) != 0 || ENTRIES < 2) begin : g_bad_entries
    $error("ENTRIES must be a power of two");
  end
  if ((THREADS & (THREADS - 1)) != 0 || THREADS < 2 || THREADS > ENTRIES) begin : g_bad_threads
    $error("THREADS must be a power of two between 2 and ENTRIES");
  end
  if (TAG_LO + TAG_W > PC_W) begin : g_bad_tag
    $error("tag field exceeds pc width");
  end

  logic [PC_W-1:0]  pcArr  [2];
  logic [TID_W-1:0] tidArr [2];
  logic [IDX_W-1:0] idxArr [2];
  logic [TAG_W-1:0] tagArr [2];

  assign pcArr[0]  = lkPc;
  assign pcArr[1]  = updPc;
  assign tidArr[0] = lkTid;
  assign tidArr[1] = updTid;

  // R1/R2: one address hash per port (0 = lookup, 1 = update)
  for (genvar p = 0; p < 2; p++) begin : g_hash
    logic [IDX_W-1:0] tidMix;
    assign tidMix    = IDX_W'(tidArr[p]) << TID_SH;
    assign idxArr[p] = pcArr[p][OFS_SHIFT +: IDX_W] ^ tidMix;
    assign tagArr[p] = pcArr[p][TAG_LO +: TAG_W];
  end

  assign rdIdx = idxArr[0];
  assign rdTag = tagArr[0];
  assign wrIdx = idxArr[1];
  assign wrTag = tagArr[1];

  // R6: flush beats a coincident write
  assign strobe.clearAll = flushReq;
  assign strobe.write    = updEn & ~flushReq;

  logic unusedPcBits;
  assign unusedPcBits = ^{lkPc, updPc};
endmodule

// File: rtl/tbtb_store.sv
module tbtb_store #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 8,
  parameter int TID_W   = 2,
  parameter int TGT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tbtb_pkg::tbtbStrobeT  strobe,
  input  logic [IDX_W-1:0]      wrIdx,
  input  logic [TAG_W-1:0]      wrTag,
  input  logic [TID_W-1:0]      wrTid,
  input  logic [TGT_W-1:0]      wrTarget,
  input  logic [IDX_W-1:0]      rdIdx,
  input  logic [TAG_W-1:0]      rdTag,
  input  logic [TID_W-1:0]      rdTid,
  output logic                  hit,
  output logic [TGT_W-1:0]      target
);
  logic [ENTRIES-1:0] validVec;
  logic [TAG_W-1:0]   tagMem [ENTRIES];
  logic [TID_W-1:0]   tidMem [ENTRIES];
  logic [TGT_W-1:0]   tgtMem [ENTRIES];

  // R6/R7: valid bits cleared by reset or flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0;
    end else if (strobe.clearAll) begin
      validVec <= '0;
    end else if (strobe.write) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  // R5: unconditional overwrite of payload
  always_ff @(posedge clk) begin
    if (strobe.write) begin
      tagMem[wrIdx] <= wrTag;
      tidMem[wrIdx] <= wrTid;
      tgtMem[wrIdx] <= wrTarget;
    end
  end

  // R3/R4/R8: combinational read of registered contents
  logic tagEq, tidEq;
  assign tagEq  = tagMem[rdIdx] == rdTag;
  assign tidEq  = tidMem[rdIdx] == rdTid;
  assign hit    = validVec[rdIdx] & tagEq & tidEq;
  assign target = hit ? tgtMem[rdIdx] : '0;

  assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.write && !strobe.clearAll) |=> validVec[$past(wrIdx)]);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clearAll |=> (validVec == '0));
endmodule

// File: rtl/tbtb_top.sv
module tbtb_top #(
  parameter int ENTRIES   = 16,
  parameter int TAG_W     = 8,
  parameter int OFS_SHIFT = 2,
  parameter int THREADS   = 4,
  parameter int PC_W      = 32,
  parameter int TGT_W     = 32,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TID_W    = $clog2(THREADS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushReq,
  input  logic [PC_W-1:0]   lkPc,
  input  logic [TID_W-1:0]  lkTid,
  output logic              lkHit,
  output logic [TGT_W-1:0]  lkTarget,
  input  logic              updEn,
  input  logic [PC_W-1:0]   updPc,
  input  logic [TID_W-1:0]  updTid,
  input  logic [TGT_W-1:0]  updTarget
);
  tbtb_pkg::tbtbStrobeT strobe;
  logic [IDX_W-1:0] rdIdx, wrIdx;
  logic [TAG_W-1:0] rdTag, wrTag;

  tbtb_ctrl #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .OFS_SHIFT(OFS_SHIFT),
    .THREADS(THREADS), .PC_W(PC_W)
  ) ctrl_i (
    .updEn(updEn), .flushReq(flushReq),
    .lkPc(lkPc), .lkTid(lkTid), .updPc(updPc), .updTid(updTid),
    .rdIdx(rdIdx), .rdTag(rdTag), .wrIdx(wrIdx), .wrTag(wrTag),
    .strobe(strobe)
  );

  tbtb_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .TGT_W(TGT_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wrIdx(wrIdx), .wrTag(wrTag), .wrTid(updTid), .wrTarget(updTarget),
    .rdIdx(rdIdx), .rdTag(rdTag), .rdTid(lkTid),
    .hit(lkHit), .target(lkTarget)
  );

  assert_update_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(updEn) && !$past(flushReq) &&
     lkPc == $past(updPc) && lkTid == $past(updTid))
    |-> (lkHit && lkTarget == $past(updTarget)));

  assert_flush_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(flushReq)) |-> !lkHit);

  assert_reset_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !lkHit);

  assert_quiet_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(updEn) && !$past(flushReq) &&
     $stable(lkPc) && $stable(lkTid)) |-> ($stable(lkHit) && $stable(lkTarget)));
endmodule

// File: tb/tbtb_top_tb_top.sv
module tbtb_top_tb_top;
  localparam int NE = 16, TW = 8, OS = 2, NT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flushReq = 1'b0;
  logic [31:0] lkPc = '0;
  logic [1:0]  lkTid = '0;
  logic        lkHit;
  logic [31:0] lkTarget;
  logic        updEn = 1'b0;
  logic [31:0] updPc = '0;
  logic [1:0]  updTid = '0;
  logic [31:0] updTarget = '0;

  int testCount = 0;
  int failCount = 0;

  always #4 clk = ~clk;

  tbtb_top dut_i (
    .clk(clk), .rst_n(rst_n), .flushReq(flushReq),
    .lkPc(lkPc), .lkTid(lkTid), .lkHit(lkHit), .lkTarget(lkTarget),
    .updEn(updEn), .updPc(updPc), .updTid(updTid), .updTarget(updTarget)
  );

  // reference model
  bit          mValid [NE];
  int unsigned mTag   [NE];
  int unsigned mTid   [NE];
  int unsigned mTgt   [NE];

  function automatic int unsigned refIdx(int unsigned pc, int unsigned tid);
    return ((pc >> OS) ^ (tid << 2)) % NE;
  endfunction
  function automatic int unsigned refTag(int unsigned pc);
    return (pc >> (OS + 4)) % 256;
  endfunction
  function automatic logic [32:0] refLook(int unsigned pc, int unsigned tid);
    int unsigned i = refIdx(pc, tid);
    if (mValid[i] && mTag[i] == refTag(pc) && mTid[i] == tid) return {1'b1, mTgt[i]};
    return 33'd0;
  endfunction
  task automatic modelClear();
    for (int i = 0; i < NE; i++) mValid[i] = 1'b0;
  endtask
  task automatic modelWrite(int unsigned pc, int unsigned tid, int unsigned tgt);
    int unsigned i = refIdx(pc, tid);
    mValid[i] = 1'b1; mTag[i] = refTag(pc); mTid[i] = tid; mTgt[i] = tgt;
  endtask

  task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got hit=%0b tgt=%h, expected hit=%0b tgt=%h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic look(int unsigned pc, int unsigned tid, string req);
    @(negedge clk);
    lkPc = pc; lkTid = tid[1:0];
    #1;
    chk(req, {lkHit, lkTarget}, refLook(pc, tid));
  endtask

  task automatic upd(int unsigned pc, int unsigned tid, int unsigned tgt);
    @(negedge clk);
    updEn = 1'b1; updPc = pc; updTid = tid[1:0]; updTarget = tgt;
    @(negedge clk);
    updEn = 1'b0;
    modelWrite(pc, tid, tgt);
  endtask

  task automatic sweep(string req);
    for (int t = 0; t < NT; t++)
      for (int w = 0; w < 128; w++)
        look(w * 4, t, req);
  endtask

  initial begin
    #(8 * 200000);
    testCount++; failCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    // R7: lookups during reset miss
    look(32'h40, 0, "R7 during reset");
    rst_n = 1'b1;
    sweep("R7 after reset");

    // R1/R2/R3: fill every slot from every thread, then full sweep
    for (int t = 0; t < NT; t++)
      for (int w = 0; w < 16; w++)
        upd((w + 16 * (t + 1)) * 4, t, 32'h1000 + w * 16 + t);
    sweep("R1/R2/R3 fill");

    // R5: tag conflicts at the same slot, last writer wins
    for (int w = 0; w < 16; w += 3) upd((w + 16 * 5) * 4, 1, 32'hA000 + w);
    sweep("R5 conflict");

    // R9: same pc for all threads lands in distinct slots
    for (int t = 0; t < NT; t++) upd(32'h1C8, t, 32'hB000 + t);
    for (int t = 0; t < NT; t++) look(32'h1C8, t, "R9 per-thread");

    // R6: flush empties the table
    @(negedge clk); flushReq = 1'b1;
    @(negedge clk); flushReq = 1'b0; modelClear();
    sweep("R6 flush");

    // R3: same slot and tag, other thread -> miss (pc 0x44/t0 and 0x54/t1 share slot 1)
    upd(32'h44, 0, 32'hC0DE);
    look(32'h54, 1, "R3 tid mismatch");
    look(32'h44, 0, "R3 owner hit");

    // R4: stored target zero still hits
    upd(32'h88, 2, 32'h0);
    look(32'h88, 2, "R4 zero target");
    look(32'h8C, 2, "R4 miss zero");

    // R8: lookup and update same slot in one cycle
    @(negedge clk);
    updEn = 1'b1; updPc = 32'h44; updTid = 2'd0; updTarget = 32'hD00D;
    lkPc = 32'h44; lkTid = 2'd0;
    #1;
    chk("R8 old contents", {lkHit, lkTarget}, {1'b1, 32'hC0DE});
    @(negedge clk);
    updEn = 1'b0; modelWrite(32'h44, 0, 32'hD00D);
    #1;
    chk("R8 new contents", {lkHit, lkTarget}, {1'b1, 32'hD00D});

    // R6: flush wins over coincident update
    @(negedge clk);
    flushReq = 1'b1; updEn = 1'b1; updPc = 32'h100; updTid = 2'd3; updTarget = 32'hEEEE;
    @(negedge clk);
    flushReq = 1'b0; updEn = 1'b0; modelClear();
    look(32'h100, 3, "R6 flush beats update");
    look(32'h44, 0, "R6 flush beats update");

    // R7: reset pulse mid-run
    upd(32'h20, 1, 32'h77);
    look(32'h20, 1, "R5 before reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; modelClear();
    sweep("R7 mid-run reset");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule